// File: doc/BRIEF.md
# Multi-Lane Receive Link Synchronizer

This block sits behind the character decoders of a multi-lane serial converter link that uses 8b/10b coding. Each lane presents one 32-bit word per link clock. The word holds four octets, and octet 0 (bits 7:0) is the earliest in time. With each octet come a control-character flag and two error flags: running disparity and not-in-table. The block owns the active-low synchronization request. It walks every lane through three phases: comma hunting, the initial lane alignment sequence and the user data phase.

During the alignment sequence the block finds the /R/ character in whichever octet position it arrives. It then re-orders the octets so that each later multiframe starts in octet 0. It checks the control-character framing of every multiframe and captures the fourteen configuration octets that each lane carries in its second multiframe. Once the sequence is complete, it raises a link-aligned flag and delivers phase-corrected user words with a start-of-multiframe marker. Any error restarts the whole link and raises an interrupt flag.

The multiframe length in octets (MF_FRAMES x FRAME_OCTETS) must be a multiple of four and at least 20. ILAS_MF must be at least 2. All lanes must present their /R/ in the same link-clock word.

Top module: `rx_link_sync`

## Requirements
- R1: After reset `sync_n_o` is 0. A lane counts successive /K/ octets (control flag 1, no error flag, value 0xBC) in octet order, carrying the count across words. Any other octet clears the count. A lane is satisfied once the count is at least four at the end of a word. `sync_n_o` is 1 only while every lane is satisfied.
- R2: After `sync_n_o` goes high, a lane needs four more /K/ octets before its first non-/K/ octet, and that octet must be /R/ (control, 0x1C). A different octet, an /R/ that arrives too early, or an octet with an error flag is an error.
- R3: The /R/ may sit in any octet position. From then on, output octets are re-ordered so that the /R/ octet becomes octet 0 of the aligned word. The user data on `rx_data_o` is therefore the same whatever the arrival phase.
- R4: The alignment sequence is ILAS_MF multiframes of MF_FRAMES x FRAME_OCTETS octets. Each multiframe must begin with /R/ and end with /A/ (control, 0x7C). A mismatch is an error, detected on the clock edge that consumes the aligned word containing it.
- R5: In the second multiframe, aligned octet 1 must be /Q/ (control, 0x9C); otherwise it is an error. Aligned octets 2..15 are stored as configuration bytes 0..13. Byte b of lane l appears at `cfg_o[l*128 + b*8 +: 8]`, and bytes 14 and 15 read 0.
- R6: `lane_aligned_o` rises after the edge that consumes the last aligned word of the sequence, provided that word is error-free. `rx_valid_o` rises one cycle later, together with the first user word.
- R7: `somf_o` is 4'b0001 on the first user word and on every MF_FRAMES x FRAME_OCTETS / 4 words after it. It is 0 on all other words and whenever `rx_valid_o` is 0.
- R8: An error on any lane sends all lanes back to hunting on the same edge. After that edge, `sync_n_o`, `lane_aligned_o` and `rx_valid_o` are 0. Error flags seen while hunting are ignored and only prevent a /K/ from counting.
- R9: `err_irq_o` is set on the edge of an error. It stays set until the link is aligned again, and clears on the edge after `lane_aligned_o` is seen high. If a set and a clear fall on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_word_i | input | LANES*32 | Decoded octets, four per lane, octet 0 in the low byte |
| rx_ctl_i | input | LANES*4 | Control-character flag per octet |
| rx_disp_err_i | input | LANES*4 | Running-disparity error per octet |
| rx_nit_err_i | input | LANES*4 | Not-in-table error per octet |
| sync_n_o | output | 1 | Synchronization request, active low |
| lane_aligned_o | output | 1 | All lanes have completed the alignment sequence |
| rx_valid_o | output | 1 | User words on rx_data_o are valid |
| rx_data_o | output | LANES*32 | Phase-corrected user words |
| somf_o | output | 4 | Start-of-multiframe octet marker |
| err_irq_o | output | 1 | Error interrupt flag |
| cfg_o | output | LANES*128 | Captured configuration bytes per lane |

## Verification
Two events can land on the same edge: the consumption of the final alignment word, which would move the link to aligned, and an error found in that same word. The bench provokes this by replacing the last /A/ of the final multiframe with a plain data octet. It then checks that, after that edge, `lane_aligned_o` stays low, `err_irq_o` is high and `sync_n_o` is low. A second pairing places a clear and a set of the interrupt flag near each other. An error is forced before alignment, and the bench confirms that the flag survives the whole alignment sequence and drops only after the link is aligned again.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam logic [7:0] CH_K = 8'hBC;
    localparam logic [7:0] CH_R = 8'h1C;
    localparam logic [7:0] CH_Q = 8'h9C;
    localparam logic [7:0] CH_A = 8'h7C;

    typedef enum logic [1:0] {
        LS_HUNT = 2'd0,
        LS_KOK  = 2'd1,
        LS_ILAS = 2'd2,
        LS_DATA = 2'd3
    } lane_st_e;

    typedef struct packed {
        logic [7:0] val;
        logic       ctl;
        logic       bad;
    } octet_t;

    // True when the octet is a clean control character with the given code.
    function automatic logic is_char(input octet_t o, input logic [7:0] code);
        return o.ctl && !o.bad && (o.val == code);
    endfunction

endpackage

// File: rtl/rxs_octet_aligner.sv
module rxs_octet_aligner
    import rxs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  octet_t [3:0]     raw_i,
    input  logic   [1:0]     phase_i,
    output octet_t [3:0]     algn_o
);

    octet_t [3:0] prev_d, prev_q;
    octet_t [7:0] win;

    always_comb begin
        prev_d = raw_i;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= prev_d;
    end

    // Window of two words: the earlier word occupies the low octets.
    assign win = {raw_i, prev_q};

    always_comb begin
        for (int o = 0; o < 4; o++) begin
            algn_o[o] = win[o + int'(phase_i)];
        end
    end

endmodule

// File: rtl/rxs_cfg_capture.sv
module rxs_cfg_capture #(
    parameter int WCW = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en_i,
    input  logic [WCW-1:0]   wcnt_i,
    input  logic [31:0]      val_i,
    output logic [127:0]     cfg_o
);

    localparam int NBYTES = 14;
    localparam int FIRST  = 2;

    logic [NBYTES-1:0][7:0] byt_d, byt_q;

    // Byte b lives at aligned octet b+FIRST: fixed word and lane octet.
    always_comb begin
        byt_d = byt_q;
        for (int b = 0; b < NBYTES; b++) begin
            if (cap_en_i && (wcnt_i == WCW'((b + FIRST) / 4))) begin
                byt_d[b] = val_i[((b + FIRST) % 4) * 8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) byt_q <= '0;
        else     byt_q <= byt_d;
    end

    assign cfg_o = {16'h0000, byt_q};

endmodule

// File: rtl/rxs_lane_fsm.sv
module rxs_lane_fsm
    import rxs_pkg::*;
#(
    parameter int MF_WORDS = 8,
    parameter int ILAS_MF  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  octet_t [3:0]     raw_i,
    input  logic             sync_rel_i,
    input  logic             restart_i,
    output logic             kok_o,
    output logic             aligned_o,
    output logic             err_o,
    output logic [31:0]      data_o,
    output logic             vld_o,
    output logic [3:0]       somf_o,
    output logic [127:0]     cfg_o
);

    localparam int WCW = (MF_WORDS > 1) ? $clog2(MF_WORDS) : 1;
    localparam int MFW = (ILAS_MF > 1) ? $clog2(ILAS_MF) : 1;
    localparam logic [WCW-1:0] W_LAST = WCW'(MF_WORDS - 1);
    localparam logic [MFW-1:0] M_LAST = MFW'(ILAS_MF - 1);
    localparam logic [MFW-1:0] M_CFG  = MFW'(1);

    typedef struct packed {
        lane_st_e         st;
        logic [2:0]       kcnt;
        logic [2:0]       chk;
        logic [1:0]       phase;
        logic [WCW-1:0]   wcnt;
        logic [MFW-1:0]   mf;
        logic [31:0]      dat;
        logic             vld;
        logic [3:0]       somf;
    } lane_t;

    lane_t        d, q;
    octet_t [3:0] algn;
    logic [31:0]  algn_val;
    logic         err;
    logic         any_bad;

    rxs_octet_aligner u_algn (
        .clk     (clk),
        .rst     (rst),
        .raw_i   (raw_i),
        .phase_i (q.phase),
        .algn_o  (algn)
    );

    always_comb begin
        for (int o = 0; o < 4; o++) algn_val[o*8 +: 8] = algn[o].val;
    end

    rxs_cfg_capture #(.WCW(WCW)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cap_en_i (q.st == LS_ILAS && q.mf == M_CFG),
        .wcnt_i   (q.wcnt),
        .val_i    (algn_val),
        .cfg_o    (cfg_o)
    );

    always_comb begin
        logic [2:0] k;
        logic [2:0] c;
        logic       done;
        d       = q;
        err     = 1'b0;
        d.vld   = 1'b0;
        d.somf  = 4'b0000;
        k       = q.kcnt;
        c       = q.chk;
        done    = 1'b0;
        any_bad = algn[0].bad | algn[1].bad | algn[2].bad | algn[3].bad;
        unique case (q.st)
            LS_HUNT: begin
                for (int i = 0; i < 4; i++) begin
                    if (is_char(raw_i[i], CH_K)) k = (k >= 3'd4) ? 3'd4 : k + 3'd1;
                    else                         k = 3'd0;
                end
                d.kcnt = k;
                if (k == 3'd4) begin
                    d.st  = LS_KOK;
                    d.chk = 3'd0;
                end
            end
            LS_KOK: begin
                for (int i = 0; i < 4; i++) begin
                    if (!done) begin
                        if (raw_i[i].bad) begin
                            err  = 1'b1;
                            done = 1'b1;
                        end else if (is_char(raw_i[i], CH_K)) begin
                            if (sync_rel_i) c = (c >= 3'd4) ? 3'd4 : c + 3'd1;
                        end else if (c == 3'd4 && is_char(raw_i[i], CH_R)) begin
                            d.phase = 2'(i);
                            d.st    = LS_ILAS;
                            d.wcnt  = '0;
                            d.mf    = '0;
                            done    = 1'b1;
                        end else begin
                            err  = 1'b1;
                            done = 1'b1;
                        end
                    end
                end
                d.chk = c;
            end
            LS_ILAS: begin
                if (any_bad) err = 1'b1;
                if (q.wcnt == '0 && !is_char(algn[0], CH_R)) err = 1'b1;
                if (q.wcnt == '0 && q.mf == M_CFG && !is_char(algn[1], CH_Q)) err = 1'b1;
                if (q.wcnt == W_LAST && !is_char(algn[3], CH_A)) err = 1'b1;
                if (q.wcnt == W_LAST) begin
                    d.wcnt = '0;
                    if (q.mf == M_LAST) d.st = LS_DATA;
                    else                d.mf = q.mf + MFW'(1);
                end else begin
                    d.wcnt = q.wcnt + WCW'(1);
                end
            end
            LS_DATA: begin
                if (any_bad) err = 1'b1;
                d.dat  = algn_val;
                d.vld  = 1'b1;
                d.somf = (q.wcnt == '0) ? 4'b0001 : 4'b0000;
                d.wcnt = (q.wcnt == W_LAST) ? '0 : q.wcnt + WCW'(1);
            end
            default: d.st = LS_HUNT;
        endcase
        if (err || restart_i) begin
            d.st   = LS_HUNT;
            d.kcnt = 3'd0;
            d.chk  = 3'd0;
            d.wcnt = '0;
            d.mf   = '0;
            d.vld  = 1'b0;
            d.somf = 4'b0000;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign kok_o     = (q.st != LS_HUNT);
    assign aligned_o = (q.st == LS_DATA);
    assign err_o     = err;
    assign data_o    = q.dat;
    assign vld_o     = q.vld;
    assign somf_o    = q.somf;

    // R2: alignment entry only after the full post-release check count
    a_r2_entry_after_check: assert property (@(posedge clk) disable iff (rst)
        (q.st == LS_ILAS && $past(q.st) == LS_KOK) |-> $past(q.chk) == 3'd4);

    // R3: the recorded octet phase never moves during alignment or data
    a_r3_phase_stable: assert property (@(posedge clk) disable iff (rst)
        ((q.st == LS_ILAS || q.st == LS_DATA) &&
         ($past(q.st) == LS_ILAS || $past(q.st) == LS_DATA)) |-> $stable(q.phase));

    // R6: the data phase is entered only from the alignment sequence
    a_r6_data_from_ilas: assert property (@(posedge clk) disable iff (rst)
        (q.st == LS_DATA && $past(q.st) != LS_DATA) |-> $past(q.st) == LS_ILAS);

    // R7: the marker is a single octet position and only on valid words
    a_r7_somf_valid: assert property (@(posedge clk) disable iff (rst)
        (q.somf != 4'b0000) |-> (q.vld && q.somf == 4'b0001));

endmodule

// File: rtl/rx_link_sync.sv
module rx_link_sync
    import rxs_pkg::*;
#(
    parameter int LANES        = 2,
    parameter int FRAME_OCTETS = 1,
    parameter int MF_FRAMES    = 32,
    parameter int ILAS_MF      = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES*32-1:0]    rx_word_i,
    input  logic [LANES*4-1:0]     rx_ctl_i,
    input  logic [LANES*4-1:0]     rx_disp_err_i,
    input  logic [LANES*4-1:0]     rx_nit_err_i,
    output logic                   sync_n_o,
    output logic                   lane_aligned_o,
    output logic                   rx_valid_o,
    output logic [LANES*32-1:0]    rx_data_o,
    output logic [3:0]             somf_o,
    output logic                   err_irq_o,
    output logic [LANES*128-1:0]   cfg_o
);

    localparam int MF_OCTETS = FRAME_OCTETS * MF_FRAMES;
    localparam int MF_WORDS  = MF_OCTETS / 4;

    typedef struct packed {
        logic irq;
    } top_t;

    top_t d, q;

    octet_t [LANES-1:0][3:0] raw;
    logic   [LANES-1:0]      kok, alg, lerr, vld;
    logic   [LANES-1:0][3:0] somf;
    logic                    any_err;

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            for (int o = 0; o < 4; o++) begin
                raw[l][o].val = rx_word_i[l*32 + o*8 +: 8];
                raw[l][o].ctl = rx_ctl_i[l*4 + o];
                raw[l][o].bad = rx_disp_err_i[l*4 + o] | rx_nit_err_i[l*4 + o];
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        rxs_lane_fsm #(
            .MF_WORDS (MF_WORDS),
            .ILAS_MF  (ILAS_MF)
        ) u_lane (
            .clk        (clk),
            .rst        (rst),
            .raw_i      (raw[l]),
            .sync_rel_i (sync_n_o),
            .restart_i  (any_err),
            .kok_o      (kok[l]),
            .aligned_o  (alg[l]),
            .err_o      (lerr[l]),
            .data_o     (rx_data_o[l*32 +: 32]),
            .vld_o      (vld[l]),
            .somf_o     (somf[l]),
            .cfg_o      (cfg_o[l*128 +: 128])
        );
    end

    assign any_err        = |lerr;
    assign sync_n_o       = &kok;
    assign lane_aligned_o = &alg;
    assign rx_valid_o     = &vld;
    assign somf_o         = somf[0];

    always_comb begin
        d     = q;
        d.irq = any_err | (q.irq & ~lane_aligned_o);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign err_irq_o = q.irq;

    // R9: an error always leaves the interrupt flag set
    a_r9_irq_on_error: assert property (@(posedge clk) disable iff (rst)
        any_err |=> err_irq_o);

    // R9: the flag holds until the link is aligned
    a_r9_irq_hold: assert property (@(posedge clk) disable iff (rst)
        (err_irq_o && !lane_aligned_o) |=> err_irq_o);

    // R8: an error restarts the link on every lane
    a_r8_restart_all: assert property (@(posedge clk) disable iff (rst)
        any_err |=> (!sync_n_o && !lane_aligned_o && !rx_valid_o));

    // R6: user words only while the link is aligned
    a_r6_valid_needs_aligned: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> lane_aligned_o);

endmodule

// File: tb/tb_rx_link_sync.sv
module tb_rx_link_sync;

    localparam int LANES  = 2;
    localparam int MFO    = 32;
    localparam int ILASO  = 4 * MFO;
    localparam int HIST   = 64;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [LANES*32-1:0]  word = '0;
    logic [LANES*4-1:0]   ctl  = '0;
    logic [LANES*4-1:0]   de   = '0;
    logic [LANES*4-1:0]   ne   = '0;
    logic                 sync_n, aligned, valid, irq;
    logic [LANES*32-1:0]  data;
    logic [3:0]           somf;
    logic [LANES*128-1:0] cfg;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic al_h [HIST];
    logic vl_h [HIST];
    logic ir_h [HIST];
    logic sy_h [HIST];
    int   data_bad, somf_bad, first_valid;
    logic sync_after_k;

    always #2 clk = ~clk;

    rx_link_sync dut (
        .clk            (clk),
        .rst            (rst),
        .rx_word_i      (word),
        .rx_ctl_i       (ctl),
        .rx_disp_err_i  (de),
        .rx_nit_err_i   (ne),
        .sync_n_o       (sync_n),
        .lane_aligned_o (aligned),
        .rx_valid_o     (valid),
        .rx_data_o      (data),
        .somf_o         (somf),
        .err_irq_o      (irq),
        .cfg_o          (cfg)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_oct(input int l, input int o, input logic [7:0] v,
                           input logic c, input logic b_disp, input logic b_nit);
        word[l*32 + o*8 +: 8] = v;
        ctl[l*4 + o]          = c;
        de[l*4 + o]           = b_disp;
        ne[l*4 + o]           = b_nit;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        word = '0; ctl = '0; de = '0; ne = '0;
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic all_k();
        for (int l = 0; l < LANES; l++)
            for (int o = 0; o < 4; o++) set_oct(l, o, 8'hBC, 1'b1, 1'b0, 1'b0);
    endtask

    // Octet i of the stream on lane l whose /R/ sits at position p: {ctl, value}
    function automatic logic [8:0] stream(input int l, input int p, input int i);
        int j, m, w;
        if (i < p) return {1'b1, 8'hBC};
        j = i - p;
        if (j < ILASO) begin
            m = j / MFO;
            w = j % MFO;
            if (w == 0)                          return {1'b1, 8'h1C};
            if (m == 1 && w == 1)                return {1'b1, 8'h9C};
            if (m == 1 && w >= 2 && w <= 15)     return {1'b0, 8'(l*16 + w - 2 + 'h30)};
            if (w == MFO - 1)                    return {1'b1, 8'h7C};
            return {1'b0, 8'(j*3 + l)};
        end
        return {1'b0, 8'((j - ILASO)*5 + l*7 + 1)};
    endfunction

    task automatic drive_word(input int n, input int p0, input int p1,
                              input int ci, input int bi);
        for (int l = 0; l < LANES; l++) begin
            int p;
            p = (l == 0) ? p0 : p1;
            for (int o = 0; o < 4; o++) begin
                logic [8:0] s;
                int i;
                i = 4*n + o;
                s = stream(l, p, i);
                if (l == 0 && i == ci) s = {1'b0, 8'h55};
                set_oct(l, o, s[7:0], s[8], 1'b0, (l == 0 && i == bi));
            end
        end
    endtask

    // Runs release plus nw stream words, recording outputs after every edge.
    task automatic run_link(input int p0, input int p1, input int ci,
                            input int bi, input int nw, input bit pre_err);
        int jd;
        logic [31:0] ew;
        do_reset();
        if (pre_err) begin
            all_k();
            step();
            all_k();
            set_oct(0, 0, 8'hBC, 1'b1, 1'b1, 1'b0);
            step();
        end
        all_k();
        step();
        sync_after_k = sync_n;
        all_k();
        step();
        data_bad = 0; somf_bad = 0; first_valid = -1; jd = 0;
        for (int n = 0; n < nw; n++) begin
            drive_word(n, p0, p1, ci, bi);
            step();
            al_h[n] = aligned; vl_h[n] = valid; ir_h[n] = irq; sy_h[n] = sync_n;
            if (valid) begin
                if (first_valid < 0) first_valid = n;
                for (int l = 0; l < LANES; l++) begin
                    int p;
                    p = (l == 0) ? p0 : p1;
                    for (int o = 0; o < 4; o++) begin
                        logic [8:0] s;
                        s = stream(l, p, p + ILASO + 4*jd + o);
                        ew[o*8 +: 8] = s[7:0];
                    end
                    if (data[l*32 +: 32] !== ew) data_bad++;
                end
                if (somf !== ((jd % 8 == 0) ? 4'b0001 : 4'b0000)) somf_bad++;
                jd++;
            end else if (somf !== 4'b0000) begin
                somf_bad++;
            end
        end
    endtask

    function automatic logic [127:0] exp_cfg(input int l);
        logic [127:0] r;
        r = '0;
        for (int b = 0; b < 14; b++) r[b*8 +: 8] = 8'(l*16 + b + 'h30);
        return r;
    endfunction

    task automatic t_reset();
        do_reset();
        chk("R1", "sync_n after reset", sync_n, 1'b0);
        chk("R6", "aligned after reset", aligned, 1'b0);
        chk("R6", "valid after reset", valid, 1'b0);
        chk("R9", "irq after reset", irq, 1'b0);
    endtask

    task automatic t_k_count();
        do_reset();
        for (int l = 0; l < LANES; l++) begin
            set_oct(l, 0, 8'h00, 1'b0, 1'b0, 1'b0);
            for (int o = 1; o < 4; o++) set_oct(l, o, 8'hBC, 1'b1, 1'b0, 1'b0);
        end
        step();
        chk("R1", "three /K/ not enough", sync_n, 1'b0);
        all_k();
        set_oct(0, 2, 8'h00, 1'b0, 1'b0, 1'b0);
        set_oct(1, 2, 8'h00, 1'b0, 1'b0, 1'b0);
        step();
        chk("R1", "broken run", sync_n, 1'b0);
        all_k();
        set_oct(1, 1, 8'h00, 1'b0, 1'b0, 1'b0);
        step();
        chk("R1", "one lane short keeps request", sync_n, 1'b0);
        all_k();
        step();
        chk("R1", "all lanes satisfied", sync_n, 1'b1);
    endtask

    task automatic t_hunt_err();
        do_reset();
        all_k();
        for (int o = 0; o < 4; o++) set_oct(0, o, 8'hBC, 1'b1, 1'b1, 1'b0);
        step();
        chk("R8", "hunt error ignored irq", irq, 1'b0);
        chk("R8", "flagged /K/ not counted", sync_n, 1'b0);
        all_k();
        step();
        chk("R8", "release after clean /K/", sync_n, 1'b1);
    endtask

    task automatic t_early_r();
        do_reset();
        all_k();
        step();
        for (int l = 0; l < LANES; l++) begin
            set_oct(l, 0, 8'h1C, 1'b1, 1'b0, 1'b0);
            for (int o = 1; o < 4; o++) set_oct(l, o, 8'h11, 1'b0, 1'b0, 1'b0);
        end
        step();
        chk("R2", "early /R/ raises irq", irq, 1'b1);
        chk("R2", "early /R/ reasserts request", sync_n, 1'b0);
    endtask

    task automatic t_check_err();
        do_reset();
        all_k();
        step();
        all_k();
        set_oct(1, 2, 8'hBC, 1'b1, 1'b0, 1'b1);
        step();
        chk("R2", "error in check characters irq", irq, 1'b1);
        chk("R2", "error in check characters request", sync_n, 1'b0);
    endtask

    task automatic t_full_a();
        run_link(0, 0, -1, -1, 45, 1'b0);
        chk("R1", "release after /K/ run", sync_after_k, 1'b1);
        chk("R6", "not aligned before last word", al_h[31], 1'b0);
        chk("R6", "aligned after last /A/", al_h[32], 1'b1);
        chk("R6", "first valid word position", first_valid, 33);
        chk("R3", "user data phase 0", data_bad, 0);
        chk("R7", "multiframe marker phase 0", somf_bad, 0);
        chk("R5", "config lane 0", cfg[127:0], exp_cfg(0));
        chk("R5", "config lane 1", cfg[255:128], exp_cfg(1));
        chk("R9", "irq clear on clean link", ir_h[44], 1'b0);
    endtask

    task automatic t_full_b();
        run_link(1, 3, -1, -1, 45, 1'b0);
        chk("R3", "user data mixed phase", data_bad, 0);
        chk("R3", "first valid mixed phase", first_valid, 33);
        chk("R7", "multiframe marker mixed phase", somf_bad, 0);
        chk("R5", "config lane 1 phase 3", cfg[255:128], exp_cfg(1));
    endtask

    task automatic t_irq_clear();
        run_link(2, 2, -1, -1, 40, 1'b1);
        chk("R9", "irq held through alignment", ir_h[31], 1'b1);
        chk("R9", "irq held on aligning edge", ir_h[32], 1'b1);
        chk("R9", "irq cleared after alignment", ir_h[39], 1'b0);
        chk("R3", "data after recovery", data_bad, 0);
    endtask

    task automatic t_missing_a();
        run_link(1, 0, 1 + MFO - 1, -1, 12, 1'b0);
        chk("R4", "no error before bad word", ir_h[7], 1'b0);
        chk("R4", "missing /A/ raises irq", ir_h[8], 1'b1);
        chk("R4", "missing /A/ reasserts request", sy_h[8], 1'b0);
    endtask

    task automatic t_bad_q();
        run_link(0, 2, MFO + 1, -1, 12, 1'b0);
        chk("R5", "no error before /Q/ word", ir_h[8], 1'b0);
        chk("R5", "missing /Q/ raises irq", ir_h[9], 1'b1);
    endtask

    task automatic t_same_cycle();
        run_link(3, 1, 3 + ILASO - 1, -1, 36, 1'b0);
        chk("R6", "aligned suppressed by last-word error", al_h[32], 1'b0);
        chk("R8", "irq on last-word error", ir_h[32], 1'b1);
        chk("R8", "request reasserted on last-word error", sy_h[32], 1'b0);
        chk("R6", "no valid after failed alignment", first_valid, -1);
    endtask

    task automatic t_data_err();
        run_link(2, 0, -1, 2 + ILASO + 12, 40, 1'b0);
        chk("R8", "valid before data error", vl_h[35], 1'b1);
        chk("R8", "valid dropped by data error", vl_h[36], 1'b0);
        chk("R8", "aligned dropped by data error", al_h[36], 1'b0);
        chk("R8", "request reasserted by data error", sy_h[36], 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_k_count();
        t_hunt_err();
        t_early_r();
        t_check_err();
        t_full_a();
        t_full_b();
        t_irq_clear();
        t_missing_a();
        t_bad_q();
        t_same_cycle();
        t_data_err();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule